// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block produces the instruction fetch address for a small 4-bit microcontroller core. An 11-bit program counter selects one byte of program ROM. On every instruction cycle, marked by a one-cycle advance strobe, the counter takes a new value. That value is the next sequential address, a jump or call target, an interrupt vector, or a return address taken from the stack.

A fixed hardware return stack holds three return addresses. Subroutine calls and interrupt entry push the address of the instruction that would have followed. Returns pop the newest entry back into the counter. When the stack is already full, a push drops the oldest entry. A pop from an empty stack yields address zero.

The instruction decoder drives the control pins as plain levels, qualified by the advance strobe. The counter and stack change only on a clock edge where the strobe is high. A ROM size parameter selects between a 1024-byte and a 2048-byte program space. With the smaller space, the top address bit stays zero and the counter wraps inside the low 10 bits.

Top module: `fetch_pc_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `rom_addr` and all three stack entries to zero, whatever the control inputs are doing.
- R2: On an edge where `step` is low, `rom_addr` and `stack_dbg` keep their values, and `jump`, `call`, `irq` and `ret` have no effect.
- R3: On a step with no control active, `rom_addr` becomes the previous value plus one, modulo the ROM size (2047 wraps to 0 in the 2048-byte configuration).
- R4: On a step with only `jump`, `rom_addr` becomes `target` and the stack is unchanged.
- R5: On a step with `call`, the previous `rom_addr` plus one (modulo the ROM size) is pushed as the new top entry, the older entries move one place deeper, and `rom_addr` becomes `target`.
- R6: On a step with `irq`, the previous `rom_addr` plus one is pushed exactly as for a call, and `rom_addr` becomes `irq_vec`; `target` is ignored.
- R7: On a step with `ret` (and no `irq` or `call`), `rom_addr` becomes the top entry, the deeper entries move one place toward the top, and the deepest entry becomes zero.
- R8: A push onto a full stack discards the deepest (oldest) entry, so three later pops return the three newest return addresses, newest first.
- R9: A pop from an empty stack loads `rom_addr` with zero and leaves all entries zero.
- R10: When several controls are active on one step, `irq` wins over `call`, `call` wins over `ret`, and `ret` wins over `jump`.
- R11: With `ROM_BYTES` = 1024, bit 10 of `rom_addr` and of every stack entry is always zero, targets and vectors are truncated to their low 10 bits, and 1023 plus one wraps to 0.
- R12: `stack_dbg` exposes the entries with the top (newest) entry at bits [10:0], the next at [21:11] and the deepest at [32:22].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Instruction cycle advance strobe |
| jump | input | 1 | Load `target` into the counter |
| call | input | 1 | Push return address, load `target` |
| irq | input | 1 | Push return address, load `irq_vec` |
| ret | input | 1 | Pop the top entry into the counter |
| target | input | 11 | Jump or call destination |
| irq_vec | input | 11 | Interrupt entry address |
| rom_addr | output | 11 | Current program ROM address |
| stack_dbg | output | 33 | Stack entries, top at the low bits |

## Verification
The bench fills the stack beyond three entries and then unwinds it. A design that dropped the newest entry instead of the oldest would return the wrong first address, and one that shifted stale data up would return a non-zero address on the fourth pop. It asserts all four controls together and then removes them one at a time, which exposes any swapped priority as a wrong `rom_addr` or a missing push. It steps across the top of the address space in both ROM configurations, because a counter that does not wrap at the configured size would leave bit 10 set in the small part. It also holds the controls high with the strobe low, which shows whether the design reacts to a control without a step.

// File: rtl/pcseq_pkg.sv
package pcseq_pkg;

  // Action taken by the sequencer on one clock edge
  typedef enum logic [2:0] {
    OP_HOLD,
    OP_SEQ,
    OP_JUMP,
    OP_CALL,
    OP_INTR,
    OP_RET
  } pc_op_e;

endpackage

// File: rtl/pcseq_arb.sv
module pcseq_arb
  import pcseq_pkg::*;
(
  input  logic   step,
  input  logic   jump,
  input  logic   call,
  input  logic   irq,
  input  logic   ret,
  output pc_op_e op,
  output logic   push,
  output logic   pop
);

  // Fixed priority: interrupt, call, return, jump, then sequential
  always_comb begin
    if (!step)     op = OP_HOLD;
    else if (irq)  op = OP_INTR;
    else if (call) op = OP_CALL;
    else if (ret)  op = OP_RET;
    else if (jump) op = OP_JUMP;
    else           op = OP_SEQ;
  end

  assign push = (op == OP_INTR) || (op == OP_CALL);
  assign pop  = (op == OP_RET);

endmodule

// File: rtl/pcseq_incr.sv
module pcseq_incr #(
  parameter int AW = 11,
  parameter int UW = 11
) (
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] nxt
);

  // Wrap inside the configured ROM size; unused upper bits stay zero
  generate
    if (UW == AW) begin : g_full
      assign nxt = pc + AW'(1);
    end else begin : g_part
      assign nxt = {{(AW-UW){1'b0}}, pc[UW-1:0] + UW'(1)};
    end
  endgenerate

endmodule

// File: rtl/pcseq_rstack.sv
module pcseq_rstack #(
  parameter int AW    = 11,
  parameter int DEPTH = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push,
  input  logic                pop,
  input  logic [AW-1:0]       push_data,
  output logic [AW-1:0]       top,
  output logic [DEPTH*AW-1:0] flat
);

  logic [AW-1:0] ent [DEPTH];

  // Entry 0 is the newest. Push shifts deeper and drops the last;
  // pop shifts toward the top and fills the deepest with zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) ent[i] <= '0;
    end else if (push) begin
      ent[0] <= push_data;
      for (int i = 1; i < DEPTH; i++) ent[i] <= ent[i-1];
    end else if (pop) begin
      for (int i = 0; i < DEPTH-1; i++) ent[i] <= ent[i+1];
      ent[DEPTH-1] <= '0;
    end
  end

  assign top = ent[0];

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_flat
      assign flat[g*AW +: AW] = ent[g];
    end
  endgenerate

  assert_push_top_R5: assert property (@(posedge clk) disable iff (rst)
    push |=> ent[0] == $past(push_data));

  assert_pop_fill_R9: assert property (@(posedge clk) disable iff (rst)
    (pop && !push) |=> ent[DEPTH-1] == '0);

  generate
    if (DEPTH >= 2) begin : g_ovf_chk
      assert_full_discard_R8: assert property (@(posedge clk) disable iff (rst)
        push |=> ent[DEPTH-1] == $past(ent[DEPTH-2]));
    end
  endgenerate

endmodule

// File: rtl/fetch_pc_seq.sv
module fetch_pc_seq
  import pcseq_pkg::*;
#(
  parameter int AW        = 11,
  parameter int ROM_BYTES = 2048,
  parameter int DEPTH     = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic                jump,
  input  logic                call,
  input  logic                irq,
  input  logic                ret,
  input  logic [AW-1:0]       target,
  input  logic [AW-1:0]       irq_vec,
  output logic [AW-1:0]       rom_addr,
  output logic [DEPTH*AW-1:0] stack_dbg
);

  localparam int            UW        = $clog2(ROM_BYTES);
  localparam logic [AW-1:0] ADDR_MASK = AW'((64'd1 << UW) - 64'd1);

  pc_op_e        op;
  logic          push, pop;
  logic [AW-1:0] pc_q, pc_d, pc_inc, stk_top;

  pcseq_arb u_arb (
    .step (step),
    .jump (jump),
    .call (call),
    .irq  (irq),
    .ret  (ret),
    .op   (op),
    .push (push),
    .pop  (pop)
  );

  pcseq_incr #(.AW(AW), .UW(UW)) u_incr (
    .pc  (pc_q),
    .nxt (pc_inc)
  );

  pcseq_rstack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .push_data (pc_inc),
    .top       (stk_top),
    .flat      (stack_dbg)
  );

  always_comb begin
    unique case (op)
      OP_SEQ:  pc_d = pc_inc;
      OP_JUMP: pc_d = target & ADDR_MASK;
      OP_CALL: pc_d = target & ADDR_MASK;
      OP_INTR: pc_d = irq_vec & ADDR_MASK;
      OP_RET:  pc_d = stk_top;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_d;
  end

  assign rom_addr = pc_q;

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(rom_addr) && $stable(stack_dbg)));

  assert_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (step && !jump && !call && !irq && !ret)
      |=> rom_addr == (($past(rom_addr) + AW'(1)) & ADDR_MASK));

  assert_irq_vec_R6: assert property (@(posedge clk) disable iff (rst)
    (step && irq) |=> rom_addr == ($past(irq_vec) & ADDR_MASK));

  assert_ret_top_R7: assert property (@(posedge clk) disable iff (rst)
    (step && ret && !irq && !call) |=> rom_addr == $past(stack_dbg[AW-1:0]));

  assert_addr_range_R11: assert property (@(posedge clk) disable iff (rst)
    (rom_addr & ~ADDR_MASK) == '0);

endmodule

// File: tb/fetch_pc_seq_tb.sv
`timescale 1ns/1ps
module fetch_pc_seq_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic        step, jump, call, irq, ret;
  logic [10:0] target, irq_vec;
  logic [10:0] rom_addr;
  logic [32:0] stack_dbg;

  logic        s_step, s_jump, s_call;
  logic [10:0] s_target;
  logic [10:0] s_addr;
  logic [32:0] s_stack;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [10:0] m_pc;
  logic [10:0] m_s0, m_s1, m_s2;

  always #4 clk = ~clk;

  fetch_pc_seq u_dut (
    .clk(clk), .rst(rst), .step(step), .jump(jump), .call(call),
    .irq(irq), .ret(ret), .target(target), .irq_vec(irq_vec),
    .rom_addr(rom_addr), .stack_dbg(stack_dbg)
  );

  fetch_pc_seq #(.ROM_BYTES(1024)) u_dut_small (
    .clk(clk), .rst(rst), .step(s_step), .jump(s_jump), .call(s_call),
    .irq(1'b0), .ret(1'b0), .target(s_target), .irq_vec(11'd0),
    .rom_addr(s_addr), .stack_dbg(s_stack)
  );

  task automatic chk(input string tag, input logic [32:0] got, input logic [32:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " addr"}, {22'd0, rom_addr}, {22'd0, m_pc});
    chk({tag, " stack"}, stack_dbg, {m_s2, m_s1, m_s0});
  endtask

  function automatic logic [10:0] inc(input logic [10:0] a);
    return a + 11'd1;
  endfunction

  // One instruction cycle: drive at negedge, model, check at next negedge
  task automatic cyc(input logic st, j, c, i, r, input logic [10:0] tgt, vec);
    step = st; jump = j; call = c; irq = i; ret = r;
    target = tgt; irq_vec = vec;
    @(posedge clk);
    if (st) begin
      if (i) begin
        m_s2 = m_s1; m_s1 = m_s0; m_s0 = inc(m_pc); m_pc = vec;
      end else if (c) begin
        m_s2 = m_s1; m_s1 = m_s0; m_s0 = inc(m_pc); m_pc = tgt;
      end else if (r) begin
        m_pc = m_s0; m_s0 = m_s1; m_s1 = m_s2; m_s2 = 11'd0;
      end else if (j) begin
        m_pc = tgt;
      end else begin
        m_pc = inc(m_pc);
      end
    end
    @(negedge clk);
    step = 1'b0; jump = 1'b0; call = 1'b0; irq = 1'b0; ret = 1'b0;
  endtask

  task automatic t_reset_R1;
    rst = 1'b1;
    step = 1'b1; jump = 1'b1; call = 1'b1; irq = 1'b1; ret = 1'b1;
    target = 11'h5A5; irq_vec = 11'h3C3;
    s_step = 1'b1; s_jump = 1'b1; s_call = 1'b0; s_target = 11'h155;
    repeat (3) @(posedge clk);
    @(negedge clk);
    m_pc = 0; m_s0 = 0; m_s1 = 0; m_s2 = 0;
    chk_state("R1 reset");
    chk("R1 small reset", {s_stack}, 33'd0);
    step = 0; jump = 0; call = 0; irq = 0; ret = 0;
    s_step = 0; s_jump = 0;
    rst = 1'b0;
    @(negedge clk);
    chk_state("R1 after release");
  endtask

  task automatic t_hold_R2;
    cyc(1, 0, 1, 0, 0, 11'h040, 0);
    cyc(0, 1, 1, 1, 1, 11'h777, 11'h666);
    chk_state("R2 no step ignores controls");
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk_state("R2 no step ignores ret");
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R2 cleanup pop");
  endtask

  task automatic t_seq_R3;
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk_state("R3 step 1");
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk_state("R3 step 2");
    cyc(1, 1, 0, 0, 0, 11'h7FE, 0);
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk_state("R3 to 2047");
    cyc(1, 0, 0, 0, 0, 0, 0);
    chk_state("R3 wrap to 0");
  endtask

  task automatic t_jump_R4;
    cyc(1, 1, 0, 0, 0, 11'h123, 11'h321);
    chk_state("R4 jump");
  endtask

  task automatic t_call_R5;
    cyc(1, 0, 1, 0, 0, 11'h200, 0);
    chk_state("R5 call");
    chk("R5 R12 top at low bits", {22'd0, stack_dbg[10:0]}, {22'd0, 11'h124});
  endtask

  task automatic t_irq_R6;
    cyc(1, 0, 0, 1, 0, 11'h555, 11'h010);
    chk_state("R6 irq");
    chk("R12 second entry", {22'd0, stack_dbg[21:11]}, {22'd0, 11'h124});
  endtask

  task automatic t_ret_R7;
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R7 ret from irq");
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R7 ret from call");
  endtask

  task automatic t_overflow_R8;
    cyc(1, 1, 0, 0, 0, 11'h100, 0);
    cyc(1, 0, 1, 0, 0, 11'h300, 0);
    cyc(1, 0, 1, 0, 0, 11'h400, 0);
    cyc(1, 0, 1, 0, 0, 11'h500, 0);
    chk_state("R8 stack full");
    cyc(1, 0, 1, 0, 0, 11'h600, 0);
    chk_state("R8 push on full");
    chk("R8 R12 deepest", {22'd0, stack_dbg[32:22]}, {22'd0, 11'h301});
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R8 pop newest");
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R8 pop second");
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R8 pop third");
    chk("R8 third addr", {22'd0, rom_addr}, {22'd0, 11'h301});
  endtask

  task automatic t_underflow_R9;
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R9 pop empty");
    chk("R9 zero addr", {22'd0, rom_addr}, 33'd0);
    cyc(1, 1, 0, 0, 0, 11'h0AA, 0);
    cyc(1, 0, 0, 0, 1, 0, 0);
    chk_state("R9 second pop empty");
  endtask

  task automatic t_prio_R10;
    cyc(1, 1, 0, 0, 0, 11'h0F0, 0);
    cyc(1, 0, 1, 0, 0, 11'h180, 0);
    cyc(1, 1, 1, 1, 1, 11'h2AA, 11'h044);
    chk_state("R10 irq wins");
    cyc(1, 1, 1, 0, 1, 11'h2BB, 0);
    chk_state("R10 call beats ret");
    cyc(1, 1, 0, 0, 1, 11'h2CC, 0);
    chk_state("R10 ret beats jump");
  endtask

  task automatic t_small_R11;
    s_step = 1; s_jump = 1; s_target = 11'h7FF;
    @(posedge clk); @(negedge clk);
    s_jump = 0;
    chk("R11 target truncated", {22'd0, s_addr}, {22'd0, 11'h3FF});
    @(posedge clk); @(negedge clk);
    chk("R11 wrap 1023 to 0", {22'd0, s_addr}, 33'd0);
    s_call = 1; s_target = 11'h7AB;
    @(posedge clk); @(negedge clk);
    s_call = 0; s_step = 0;
    chk("R11 call truncated", {22'd0, s_addr}, {22'd0, 11'h3AB});
    chk("R11 pushed entry", s_stack, {22'd0, 11'h001});
    s_step = 1; s_jump = 1; s_target = 11'h3FF;
    @(posedge clk); @(negedge clk);
    s_jump = 0; s_call = 1; s_target = 11'h000;
    @(posedge clk); @(negedge clk);
    s_call = 0; s_step = 0;
    chk("R11 pushed wrap", s_stack, {11'd0, 11'h001, 11'h000});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    step = 0; jump = 0; call = 0; irq = 0; ret = 0;
    target = 0; irq_vec = 0;
    s_step = 0; s_jump = 0; s_call = 0; s_target = 0;
    rst = 1'b1;
    @(negedge clk);
    t_reset_R1();
    t_hold_R2();
    t_seq_R3();
    t_jump_R4();
    t_call_R5();
    t_irq_R6();
    t_ret_R7();
    t_overflow_R8();
    t_underflow_R9();
    t_prio_R10();
    t_small_R11();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule